// File: doc/BRIEF.md
# Card Host Status and Interrupt Unit

This block collects the event and error indications of a memory-card host controller into one 32-bit status word and turns them into a single interrupt request. The command engine, the data engine, the buffer logic and the card-detect logic each report events as single-cycle pulses. Each pulse sets a sticky flag that stays set until software writes a one to its position. A few bits are not sticky. They follow live conditions: the card bus clock running, and the data buffer being ready for a read or for a write.

A 32-bit interrupt-enable word selects which flags may raise the interrupt. The enable bits do not sit at the same positions as the status bits they gate, so a fixed routing table pairs each enable with its flag. A separate error summary output reports whether any of the five error flags is set. A two-bit completion code from the write path is captured when a write CRC error is reported.

Top module: `sdhost_irq_status`

## Requirements
- R1: While `rst` is high at a clock edge, the status word, the enable word, `err_any_o` and `irq_o` all become zero.
- R2: A pulse on `ev_pulse[i]`, where i is one of the sticky positions 31 (card inserted), 30 (card removed), 14 (SDIO interrupt), 13 (command response ended), 12 (write done), 11 (read or transfer done), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) or 0 (read timeout), sets `status_o[i]` from the next cycle on. A pulse at any other position has no effect.
- R3: A status write (`st_wr_en` high) clears every sticky flag whose data bit is 1 from the next cycle on. Flags whose data bit is 0 keep their value, and a flag with no event and no write keeps its value.
- R4: When an event pulse and a clearing write hit the same flag in one cycle, the event wins and the flag stays set.
- R5: `status_o[8]` shows `card_clk_running`, `status_o[7]` shows `buf_rd_ready` and `status_o[6]` shows `buf_wr_ready`, each one cycle later. Writes to these positions have no effect.
- R6: `status_o[10:9]` loads `wr_crc_code` in the cycle after a pulse on `ev_pulse[2]`. Code 2 means the card returned no CRC status. The code returns to 0 when flag 2 is cleared without a new event. Writes to bits 10:9 themselves have no effect.
- R7: An enable write (`ie_wr_en` high) stores the data bits at positions 15, 14, 13, 4, 3, 2, 1 and 0 from the next cycle on. All other enable bits read 0.
- R8: `irq_o` is a register holding the OR of the pairs enable15&status31, enable14&status30, enable13&status14, enable4&status7, enable3&status6, enable2&status13, enable1&status12 and enable0&status11. It follows the status and enable words one cycle later, so it drops in the cycle after the last enabled flag clears.
- R9: `err_any_o` equals the OR of status bits 5, 3, 2, 1 and 0 (mask 0x2f), in the same cycle as the status word.
- R10: Status bits 29 down to 15 and bit 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_pulse | input | 32 | Event pulses, one at each status position they set |
| wr_crc_code | input | 2 | Write completion code, valid with `ev_pulse[2]` |
| card_clk_running | input | 1 | Live condition: card bus clock running |
| buf_rd_ready | input | 1 | Live condition: buffer holds data to read |
| buf_wr_ready | input | 1 | Live condition: buffer can take data |
| st_wr_en | input | 1 | Status write strobe (write one to clear) |
| st_wr_data | input | 32 | Status write data |
| ie_wr_en | input | 1 | Enable write strobe |
| ie_wr_data | input | 32 | Enable write data |
| status_o | output | 32 | Status word |
| ie_o | output | 32 | Interrupt-enable word |
| err_any_o | output | 1 | Error summary |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that events set their flags, that clearing writes clear only the flags that have no event, that flags hold when neither an event nor a write arrives, and that the live bits lag their inputs by one cycle. They also check that the error summary matches the low error bits, that reserved bits stay zero, and that the interrupt rises and falls one cycle after the routed enable-and-flag pairs. Only the bench's scenarios can show some behaviours. These are the race between an event and a clear on the same flag with a known result, the capture of the no-CRC code and its removal when flag 2 clears, and the full path from an enable write through an event to the interrupt and back down. Mixed random traffic against a bench model then covers combinations the directed cases do not reach.

// File: rtl/sdhirq_pkg.sv
package sdhirq_pkg;
  localparam int REG_W = 32;
  // sticky event positions: 31,30,14,13,12,11,5,3,2,1,0
  localparam logic [REG_W-1:0] STICKY_MASK = 32'hC000_782F;
  localparam logic [REG_W-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [REG_W-1:0] IE_MASK     = 32'h0000_E01F;
  localparam int LIVE_N   = 3;
  localparam int LIVE_LO  = 6;   // bits 8:6 = {clk running, rd ready, wr ready}
  localparam int CODE_W   = 2;
  localparam int CODE_LO  = 9;
  localparam int WRCRC_B  = 2;
  localparam int IRQ_N    = 8;
  localparam int IE_POS [IRQ_N] = '{15, 14, 13, 4, 3, 2, 1, 0};
  localparam int ST_POS [IRQ_N] = '{31, 30, 14, 7, 6, 13, 12, 11};
endpackage

// File: rtl/sdhirq_sticky_bank.sv
module sdhirq_sticky_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  logic unused_bits;
  assign unused_bits = ^{ev & ~MASK, clr_data & ~MASK};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      // a new event overrides a clear landing in the same cycle
      assign nxt[i] = ev[i] | (q[i] & ~(clr_en & clr_data[i]));
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= nxt[i];
      end
    end else begin : g_none
      assign nxt[i] = 1'b0;
      assign q[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/sdhirq_live_sync.sv
module sdhirq_live_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] live_in,
  output logic [N-1:0] live_q
);
  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= live_in;
  end
endmodule

// File: rtl/sdhirq_irq_gate.sv
module sdhirq_irq_gate
  import sdhirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] status,
  input  logic [REG_W-1:0] enable,
  output logic             irq
);
  logic [IRQ_N-1:0] hit;
  logic unused_gate;
  assign unused_gate = ^{status, enable};

  for (genvar k = 0; k < IRQ_N; k++) begin : g_pair
    assign hit[k] = status[ST_POS[k]] & enable[IE_POS[k]];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end
endmodule

// File: rtl/sdhost_irq_status.sv
module sdhost_irq_status
  import sdhirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev_pulse,
  input  logic [1:0]       wr_crc_code,
  input  logic             card_clk_running,
  input  logic             buf_rd_ready,
  input  logic             buf_wr_ready,
  input  logic             st_wr_en,
  input  logic [REG_W-1:0] st_wr_data,
  input  logic             ie_wr_en,
  input  logic [REG_W-1:0] ie_wr_data,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] ie_o,
  output logic             err_any_o,
  output logic             irq_o
);
  logic [REG_W-1:0]  flag_nxt, flag_q;
  logic [LIVE_N-1:0] live_q;
  logic [CODE_W-1:0] code_q;
  logic [REG_W-1:0]  ie_q;
  logic              err_q;

  sdhirq_sticky_bank #(.W(REG_W), .MASK(STICKY_MASK)) u_flags (
    .clk(clk), .rst(rst), .ev(ev_pulse), .clr_en(st_wr_en),
    .clr_data(st_wr_data), .nxt(flag_nxt), .q(flag_q)
  );

  sdhirq_live_sync #(.N(LIVE_N)) u_live (
    .clk(clk), .rst(rst),
    .live_in({card_clk_running, buf_rd_ready, buf_wr_ready}),
    .live_q(live_q)
  );

  // write completion code follows the write-CRC flag
  always_ff @(posedge clk) begin
    if (rst)                                   code_q <= '0;
    else if (ev_pulse[WRCRC_B])                code_q <= wr_crc_code;
    else if (st_wr_en && st_wr_data[WRCRC_B])  code_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           ie_q <= '0;
    else if (ie_wr_en) ie_q <= ie_wr_data & IE_MASK;
  end

  // summary registered from next-state so it lines up with the flags
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |(flag_nxt & ERR_MASK);
  end

  always_comb begin
    status_o = flag_q;
    status_o[CODE_LO +: CODE_W] = code_q;
    status_o[LIVE_LO +: LIVE_N] = live_q;
  end

  sdhirq_irq_gate u_gate (
    .clk(clk), .rst(rst), .status(status_o), .enable(ie_q), .irq(irq_o)
  );

  assign ie_o      = ie_q;
  assign err_any_o = err_q;
endmodule

// File: rtl/sdhirq_checker.sv
module sdhirq_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] ev_pulse,
  input logic [1:0]  wr_crc_code,
  input logic        card_clk_running,
  input logic        buf_rd_ready,
  input logic        buf_wr_ready,
  input logic        st_wr_en,
  input logic [31:0] st_wr_data,
  input logic        ie_wr_en,
  input logic [31:0] ie_wr_data,
  input logic [31:0] status_o,
  input logic [31:0] ie_o,
  input logic        err_any_o,
  input logic        irq_o
);
  localparam logic [31:0] STK  = 32'hC000_782F;
  localparam logic [31:0] RSVD = 32'h3FFF_8010;
  logic [31:0] ev_s, clr_s;
  logic src_hit;
  assign ev_s  = ev_pulse & STK;
  assign clr_s = st_wr_en ? (st_wr_data & ~ev_pulse & STK) : 32'h0;
  assign src_hit = (ie_o[15] & status_o[31]) | (ie_o[14] & status_o[30]) |
                   (ie_o[13] & status_o[14]) | (ie_o[4]  & status_o[7])  |
                   (ie_o[3]  & status_o[6])  | (ie_o[2]  & status_o[13]) |
                   (ie_o[1]  & status_o[12]) | (ie_o[0]  & status_o[11]);

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_s != 0) |=> ((status_o & $past(ev_s)) == $past(ev_s)));
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_s != 0) |=> ((status_o & $past(clr_s)) == 0));
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!st_wr_en && ev_pulse == 0) |=> ((status_o & STK) == ($past(status_o) & STK)));
  a_r5_live_lag: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status_o[8:6] == $past({card_clk_running, buf_rd_ready, buf_wr_ready})));
  a_r6_code_load: assert property (@(posedge clk) disable iff (rst)
    ev_pulse[2] |=> (status_o[10:9] == $past(wr_crc_code)));
  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    (!ev_pulse[2] && !(st_wr_en && st_wr_data[2])) |=> $stable(status_o[10:9]));
  a_r7_ie_write: assert property (@(posedge clk) disable iff (rst)
    ie_wr_en |=> (ie_o == ($past(ie_wr_data) & 32'h0000_E01F)));
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    src_hit |=> irq_o);
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(src_hit));
  a_r9_err_summary: assert property (@(posedge clk) disable iff (rst)
    err_any_o == ((status_o & 32'h2F) != 0));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (status_o & RSVD) == 0);
endmodule

bind sdhost_irq_status sdhirq_checker u_chk (.*);

// File: tb/sdhost_irq_status_bench.sv
module sdhost_irq_status_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] STK = 32'hC000_782F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] ev_pulse = '0, st_wr_data = '0, ie_wr_data = '0;
  logic [1:0]  wr_crc_code = '0;
  logic card_clk_running = 1'b0, buf_rd_ready = 1'b0, buf_wr_ready = 1'b0;
  logic st_wr_en = 1'b0, ie_wr_en = 1'b0;
  logic [31:0] status_o, ie_o;
  logic err_any_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_st = '0, exp_ie = '0;
  logic exp_irq = 1'b0, exp_err = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sdhost_irq_status u_sdhost_irq_status (.*);

  function automatic logic irq_of(input logic [31:0] s, input logic [31:0] e);
    return (e[15] & s[31]) | (e[14] & s[30]) | (e[13] & s[14]) | (e[4] & s[7]) |
           (e[3] & s[6]) | (e[2] & s[13]) | (e[1] & s[12]) | (e[0] & s[11]);
  endfunction

  function automatic logic [31:0] st_next(input logic [31:0] s, input logic [31:0] ev,
      input logic [1:0] code, input logic [2:0] live, input logic we, input logic [31:0] wd);
    logic [31:0] clr, n;
    clr = we ? (wd & STK) : 32'h0;
    n = ((s & STK) & ~clr) | (ev & STK);
    if (ev[2])        n[10:9] = code;
    else if (clr[2])  n[10:9] = 2'd0;
    else              n[10:9] = s[10:9];
    n[8:6] = live;
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2/R3 sticky flags", status_o & STK, exp_st & STK);
    chk("R5 live bits", {29'd0, status_o[8:6]}, {29'd0, exp_st[8:6]});
    chk("R6 code field", {30'd0, status_o[10:9]}, {30'd0, exp_st[10:9]});
    chk("R10 reserved bits", status_o & 32'h3FFF_8010, 32'h0);
    chk("R7 enable word", ie_o, exp_ie);
    chk("R8 irq", {31'd0, irq_o}, {31'd0, exp_irq});
    chk("R9 error summary", {31'd0, err_any_o}, {31'd0, exp_err});
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [31:0] ev, input logic [1:0] code, input logic [2:0] live,
      input logic swe, input logic [31:0] swd, input logic iwe, input logic [31:0] iwd);
    logic [31:0] n_st;
    ev_pulse = ev; wr_crc_code = code;
    {card_clk_running, buf_rd_ready, buf_wr_ready} = live;
    st_wr_en = swe; st_wr_data = swd; ie_wr_en = iwe; ie_wr_data = iwd;
    n_st = st_next(exp_st, ev, code, live, swe, swd);
    exp_irq = irq_of(exp_st, exp_ie);
    if (iwe) exp_ie = iwd & 32'h0000_E01F;
    exp_st = n_st;
    exp_err = (n_st & 32'h2F) != 0;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_all();
    chk("R1 status after reset", status_o, 32'h0);

    // R2: pulse at a non-sticky position is ignored
    step(32'h0010_0010, 2'd0, 3'b000, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R2 non-sticky event ignored", status_o, 32'h0);

    // R8: enable command-end, then event, irq one cycle after flag
    step(32'h0, 2'd0, 3'b000, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF);
    chk("R7 enable mask", ie_o, 32'h0000_E01F);
    step(32'h0000_2000, 2'd0, 3'b000, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R8 irq not yet high", {31'd0, irq_o}, 32'd0);
    step(32'h0, 2'd0, 3'b000, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R8 irq high", {31'd0, irq_o}, 32'd1);

    // R4: event and clear on bit 13 together, event wins
    step(32'h0000_2000, 2'd0, 3'b000, 1'b1, 32'h0000_2000, 1'b0, 32'h0);
    chk("R4 event wins over clear", {31'd0, status_o[13]}, 32'd1);

    // R3 / R8: clear, irq drops one cycle later
    step(32'h0, 2'd0, 3'b000, 1'b1, 32'h0000_2000, 1'b0, 32'h0);
    chk("R3 flag cleared", {31'd0, status_o[13]}, 32'd0);
    chk("R8 irq still high", {31'd0, irq_o}, 32'd1);
    step(32'h0, 2'd0, 3'b000, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);

    // R6: no-CRC code capture, write to code bits ignored, clear with flag 2
    step(32'h0000_0004, 2'd2, 3'b000, 1'b0, 32'h0, 1'b0, 32'h0);
    chk("R6 no-CRC code", {30'd0, status_o[10:9]}, 32'd2);
    chk("R9 error summary set", {31'd0, err_any_o}, 32'd1);
    step(32'h0, 2'd0, 3'b000, 1'b1, 32'h0000_0600, 1'b0, 32'h0);
    chk("R6 code write ignored", {30'd0, status_o[10:9]}, 32'd2);
    step(32'h0, 2'd0, 3'b000, 1'b1, 32'h0000_0004, 1'b0, 32'h0);
    chk("R6 code cleared with flag", {30'd0, status_o[10:9]}, 32'd0);
    chk("R9 error summary clear", {31'd0, err_any_o}, 32'd0);

    // R5: live bits follow inputs and ignore writes
    step(32'h0, 2'd0, 3'b101, 1'b1, 32'h0000_01C0, 1'b0, 32'h0);
    chk("R5 live bits follow", {29'd0, status_o[8:6]}, 32'd5);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev, swd, iwd;
      logic swe, iwe;
      ev  = $urandom() & $urandom() & $urandom();
      swe = ($urandom() % 4) == 0;
      swd = $urandom();
      iwe = ($urandom() % 8) == 0;
      iwd = $urandom();
      step(ev, 2'($urandom()), 3'($urandom()), swe, swd, iwe, iwd);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule